// File: doc/BRIEF.md
# PCI Interrupt Router with Legacy-Routing Autodetect

This block takes the four interrupt pins (INTA..INTD) of every device slot behind a PCI host bridge and folds them onto four system interrupt lines. Two board variants exist. Variant A rotates each pin by slot number plus two. Variant B rotates by slot number plus three. Some older guest software assumes a legacy routing in which pin n always lands on line n. The block therefore snoops configuration writes to find out which routing the software expects.

A sticky three-state mode register starts from a value given at reset. In variant A, the first write to a device's interrupt-line register is compared with the values that the known-bad software writes. The mode then either locks into the legacy pass-through routing, locks into the correct rotated routing, or stays undecided when the value does not settle the question. Once the mode is locked, no later write can change it until the next reset.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted and until the first write is classified, mode_o equals reset_mode_i, decoded as 0 = undecided, 1 = legacy pass-through, 2 = locked correct. The value 3 is treated as 0. mode_o never shows 3.
- R2: A write is classified only when all of these hold: cfg_wr_i is high, variant_i is 0 (variant A), cfg_addr_i[7:0] equals 0x3C, and the mode is undecided. Any other write leaves the mode unchanged.
- R3: The slot number is cfg_addr_i[15:11] (the device/function byte cfg_addr_i[15:8] shifted right by 3). Classification uses s = slot mod 4 = cfg_addr_i[12:11] and only cfg_wdata_i[7:0].
- R4: The byte v is classified with these rules, checked in order: v = 27 with s = 2 keeps the mode undecided; v = 27 with any other s gives pass-through; v = 27 + s gives pass-through; v = 91 + s gives pass-through; any other value gives locked correct.
- R5: Once the mode is pass-through or locked correct, it keeps that value until reset.
- R6: In pass-through mode, pin p of every slot drives irq_o[p].
- R7: Outside pass-through mode, variant A routes pin p of slot t to irq_o[(t + p + 2) mod 4]. Pin group k on pin_lvl_i (bits 4k+3..4k, pin p at bit 4k+p) belongs to slot t = SLOT_BASE + k, where SLOT_BASE defaults to 11.
- R8: Outside pass-through mode, variant B (variant_i = 1) routes pin p of slot t to irq_o[(t + p + 3) mod 4].
- R9: Each irq_o bit is the OR of all pins routed to it. When every pin is low, irq_o is 0.
- R10: A classifying write changes mode_o, and with it the routing, only after the rising clock edge that samples the write. irq_o follows pin_lvl_i with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reset_mode_i | input | 2 | Mode value loaded by reset |
| variant_i | input | 1 | Board variant: 0 = A (with autodetect), 1 = B |
| cfg_wr_i | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr_i | input | ADDR_W (24) | Configuration write address |
| cfg_wdata_i | input | DATA_W (32) | Configuration write data |
| pin_lvl_i | input | 4*NUM_SLOTS (16) | Interrupt pin levels, 4 per slot |
| irq_o | output | 4 | System interrupt lines |
| mode_o | output | 2 | Current routing mode |

## Verification
The hardest behaviour to reach is the classification itself, because each decision can be made only once per reset: after one qualifying write the mode is locked. The stimulus therefore resets before every vector of the classification table. Each vector is a single crafted write, with the device/function byte picking the slot remainder and the data carrying the byte of interest, sometimes with upper data bits or function bits set. Stickiness and the one-edge delay are then shown with directed sequences: a second conflicting write, and the routing observed just before and just after the deciding edge.

// File: rtl/pir_pkg.sv
package pir_pkg;
  typedef enum logic [1:0] {
    MODE_UNDECIDED = 2'd0,
    MODE_LEGACY    = 2'd1,
    MODE_LOCKED    = 2'd2
  } mode_e;

  localparam int unsigned PINS = 4;
  localparam logic [7:0] LINE_REG_OFS = 8'h3C;
  localparam logic [7:0] OLD_BASE     = 8'd27;
  localparam logic [7:0] OFS_BASE     = 8'd91;

  function automatic mode_e decode_mode(input logic [1:0] raw);
    case (raw)
      2'd1:    return MODE_LEGACY;
      2'd2:    return MODE_LOCKED;
      default: return MODE_UNDECIDED;
    endcase
  endfunction
endpackage

// File: rtl/pir_classify.sv
module pir_classify
  import pir_pkg::*;
(
  input  logic [1:0] slot_mod_i,
  input  logic [7:0] line_val_i,
  output mode_e      verdict_o
);
  logic [7:0] slot_ext;
  assign slot_ext = {6'd0, slot_mod_i};

  // order matters: slot-2 exception before generic 27 match
  always_comb begin
    if (line_val_i == OLD_BASE)
      verdict_o = (slot_mod_i == 2'd2) ? MODE_UNDECIDED : MODE_LEGACY;
    else if (line_val_i == OLD_BASE + slot_ext)
      verdict_o = MODE_LEGACY;
    else if (line_val_i == OFS_BASE + slot_ext)
      verdict_o = MODE_LEGACY;
    else
      verdict_o = MODE_LOCKED;
  end
endmodule

// File: rtl/pir_mode_fsm.sv
module pir_mode_fsm
  import pir_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] reset_mode_i,
  input  logic       variant_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] reg_ofs_i,
  input  logic [1:0] slot_mod_i,
  input  logic [7:0] line_val_i,
  output mode_e      mode_o
);
  logic  init_q;
  mode_e mode_q, mode_cur, mode_d, verdict;
  logic  hit;

  pir_classify u_cls (
    .slot_mod_i (slot_mod_i),
    .line_val_i (line_val_i),
    .verdict_o  (verdict)
  );

  // until the first edge after reset the strapped value is live
  assign mode_cur = init_q ? mode_q : decode_mode(reset_mode_i);
  assign hit = cfg_wr_i && !variant_i && (reg_ofs_i == LINE_REG_OFS)
               && (mode_cur == MODE_UNDECIDED);
  assign mode_d = hit ? verdict : mode_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      mode_q <= MODE_UNDECIDED;
    end else begin
      init_q <= 1'b1;
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_cur;

  // R5
  sticky_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && mode_q != MODE_UNDECIDED) |=> $stable(mode_q));

  // R2
  variant_b_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && variant_i) |=> $stable(mode_q));

  // R2
  other_reg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && (!cfg_wr_i || reg_ofs_i != LINE_REG_OFS)) |=> $stable(mode_q));

  // R1
  always_comb mode_legal_chk: assert (mode_o != 2'd3);
endmodule

// File: rtl/pir_route.sv
module pir_route
  import pir_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_BASE = 11,
  localparam int unsigned PIN_W = NUM_SLOTS * PINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             variant_i,
  input  logic [PIN_W-1:0] pin_lvl_i,
  output logic [PINS-1:0]  irq_o
);
  logic [1:0] tgt [NUM_SLOTS][PINS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam logic [1:0] TGT_A = 2'((SLOT_BASE + k + p + 2) % PINS);
      localparam logic [1:0] TGT_B = 2'((SLOT_BASE + k + p + 3) % PINS);
      localparam logic [1:0] TGT_L = 2'(p);
      assign tgt[k][p] = (mode_i == MODE_LEGACY) ? TGT_L
                         : (variant_i ? TGT_B : TGT_A);
    end
  end

  always_comb begin
    irq_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      for (int p = 0; p < PINS; p++)
        irq_o[tgt[k][p]] = irq_o[tgt[k][p]] | pin_lvl_i[k*PINS+p];
  end

  // R9
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_lvl_i == '0) |-> (irq_o == '0));

  // R9
  no_phantom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(irq_o) <= $countones(pin_lvl_i)));
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pir_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned SLOT_BASE = 11,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned PIN_W    = NUM_SLOTS * PINS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reset_mode_i,
  input  logic              variant_i,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [PIN_W-1:0]  pin_lvl_i,
  output logic [PINS-1:0]   irq_o,
  output logic [1:0]        mode_o
);
  mode_e mode;

  logic unused_bits;
  assign unused_bits = ^{cfg_addr_i[ADDR_W-1:13], cfg_addr_i[10:8],
                         cfg_wdata_i[DATA_W-1:8]};

  pir_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reset_mode_i (reset_mode_i),
    .variant_i    (variant_i),
    .cfg_wr_i     (cfg_wr_i),
    .reg_ofs_i    (cfg_addr_i[7:0]),
    .slot_mod_i   (cfg_addr_i[12:11]),
    .line_val_i   (cfg_wdata_i[7:0]),
    .mode_o       (mode)
  );

  pir_route #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_BASE (SLOT_BASE)
  ) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .variant_i (variant_i),
    .pin_lvl_i (pin_lvl_i),
    .irq_o     (irq_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;
  localparam int NS = 4;
  localparam int SB = 11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  reset_mode_i = 2'd0;
  logic        variant_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [23:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [15:0] pin_lvl_i = '0;
  logic [3:0]  irq_o;
  logic [1:0]  mode_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pci_irq_router uut (
    .clk_i(clk), .rst_ni(rst_ni), .reset_mode_i(reset_mode_i),
    .variant_i(variant_i), .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .pin_lvl_i(pin_lvl_i),
    .irq_o(irq_o), .mode_o(mode_o)
  );

  // {variant, reg offset, devfn, data[15:0], expected mode}
  localparam int NV = 14;
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 8'h3C, 8'h70, 16'd27,   2'd0}, // R4 27 on s=2 stays
    {1'b0, 8'h3C, 8'h60, 16'd27,   2'd1}, // R4 27 on s=0
    {1'b0, 8'h3C, 8'h78, 16'd27,   2'd1}, // R4 27 on s=3
    {1'b0, 8'h3C, 8'h68, 16'd28,   2'd1}, // R4 27+s
    {1'b0, 8'h3C, 8'h78, 16'd30,   2'd1}, // R4 27+s
    {1'b0, 8'h3C, 8'h60, 16'd91,   2'd1}, // R4 91+s
    {1'b0, 8'h3C, 8'h70, 16'd93,   2'd1}, // R4 91+s
    {1'b0, 8'h3C, 8'h68, 16'd91,   2'd2}, // R4 91 on s=1
    {1'b0, 8'h3C, 8'h60, 16'd29,   2'd2}, // R4 other value
    {1'b0, 8'h3D, 8'h60, 16'd27,   2'd0}, // R2 wrong offset
    {1'b1, 8'h3C, 8'h60, 16'd27,   2'd0}, // R2 variant B
    {1'b0, 8'h3C, 8'h61, 16'h015B, 2'd1}, // R3 upper data, function bits
    {1'b0, 8'h3C, 8'hE8, 16'd28,   2'd1}, // R3 slot 29 -> s=1
    {1'b0, 8'h3C, 8'hF0, 16'd28,   2'd2}  // R3 slot 30 -> s=2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] rm, input logic var_sel);
    @(negedge clk);
    rst_ni = 1'b0;
    reset_mode_i = rm;
    variant_i = var_sel;
    cfg_wr_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] devfn, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_i = 1'b1;
    cfg_addr_i = {8'h00, devfn, ofs};
    cfg_wdata_i = d;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  function automatic logic [3:0] route_exp(input logic [15:0] pins, input int md, input logic v);
    logic [3:0] r = '0;
    for (int k = 0; k < NS; k++)
      for (int p = 0; p < 4; p++)
        if (pins[k*4+p]) begin
          if (md == 1) r[p] = 1'b1;
          else r[(SB + k + p + (v ? 3 : 2)) % 4] = 1'b1;
        end
    return r;
  endfunction

  task automatic sweep_pins(input int md, input logic v, input string req);
    for (int i = 0; i < 16; i++) begin
      pin_lvl_i = 16'(1 << i);
      #1;
      chk(req, 32'(irq_o), 32'(route_exp(pin_lvl_i, md, v)));
    end
    pin_lvl_i = '0;
    #1;
    chk("R9 idle", 32'(irq_o), 32'h0);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state, during reset and after
    reset_mode_i = 2'd0;
    #1;
    chk("R1 in reset", 32'(mode_o), 32'd0);
    do_reset(2'd1, 1'b0);
    chk("R1 legacy strap", 32'(mode_o), 32'd1);
    do_reset(2'd2, 1'b0);
    chk("R1 locked strap", 32'(mode_o), 32'd2);
    do_reset(2'd3, 1'b0);
    chk("R1 value 3", 32'(mode_o), 32'd0);

    // R4 table
    for (int n = 0; n < NV; n++) begin
      do_reset(2'd0, VEC[n][34]);
      cfg_write(VEC[n][33:26], VEC[n][25:18], {16'h0, VEC[n][17:2]});
      chk($sformatf("R4 vector %0d", n), 32'(mode_o), 32'(VEC[n][1:0]));
    end

    // R2 strobe low: no effect
    do_reset(2'd0, 1'b0);
    @(negedge clk);
    cfg_addr_i = {8'h00, 8'h60, 8'h3C};
    cfg_wdata_i = 32'd27;
    @(negedge clk);
    chk("R2 no strobe", 32'(mode_o), 32'd0);

    // R5 sticky: locked then legacy pattern
    do_reset(2'd0, 1'b0);
    cfg_write(8'h3C, 8'h60, 32'd40);
    chk("R5 lock", 32'(mode_o), 32'd2);
    cfg_write(8'h3C, 8'h60, 32'd27);
    chk("R5 sticky locked", 32'(mode_o), 32'd2);
    do_reset(2'd0, 1'b0);
    cfg_write(8'h3C, 8'h68, 32'd28);
    cfg_write(8'h3C, 8'h68, 32'd50);
    chk("R5 sticky legacy", 32'(mode_o), 32'd1);
    // undecided verdict allows a later decision
    do_reset(2'd0, 1'b0);
    cfg_write(8'h3C, 8'h70, 32'd27);
    cfg_write(8'h3C, 8'h60, 32'd91);
    chk("R4 second try", 32'(mode_o), 32'd1);

    // R7 / R8 / R6 routing sweeps
    do_reset(2'd0, 1'b0);
    sweep_pins(0, 1'b0, "R7 variant A");
    do_reset(2'd0, 1'b1);
    sweep_pins(0, 1'b1, "R8 variant B");
    do_reset(2'd2, 1'b1);
    sweep_pins(2, 1'b1, "R8 locked B");
    do_reset(2'd1, 1'b0);
    sweep_pins(1, 1'b0, "R6 legacy A");
    do_reset(2'd1, 1'b1);
    sweep_pins(1, 1'b1, "R6 legacy B");

    // R9 OR combining
    do_reset(2'd0, 1'b0);
    pin_lvl_i = 16'b0000_0000_0001_0010; // slot11 pin1, slot12 pin0 -> both line 2
    #1;
    chk("R9 shared line", 32'(irq_o), 32'h4);
    pin_lvl_i = 16'hFFFF;
    #1;
    chk("R9 all pins", 32'(irq_o), 32'hF);
    pin_lvl_i = 16'b0000_0000_0000_0101; // slot11 pins 0,2 -> lines 1,3
    #1;
    chk("R9 two lines", 32'(irq_o), 32'hA);

    // R10 mode change visible only after the sampling edge
    do_reset(2'd0, 1'b0);
    pin_lvl_i = 16'h0001; // slot11 pin0: A -> line 1, legacy -> line 0
    @(negedge clk);
    cfg_wr_i = 1'b1;
    cfg_addr_i = {8'h00, 8'h78, 8'h3C};
    cfg_wdata_i = 32'd94;
    #1;
    chk("R10 before edge mode", 32'(mode_o), 32'd0);
    chk("R10 before edge irq", 32'(irq_o), 32'h2);
    @(negedge clk);
    cfg_wr_i = 1'b0;
    chk("R10 after edge mode", 32'(mode_o), 32'd1);
    chk("R10 after edge irq", 32'(irq_o), 32'h1);
    pin_lvl_i = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule